// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block is the interrupt half of a general-purpose I/O port. It watches the already-synchronized level of every pin, decides once per clock whether that pin's trigger condition has happened, and records the result in a sticky status register. Each pin can trigger on a low level, a high level, a rising edge or a falling edge. A separate per-pin override makes a pin trigger on both edges, whatever its code says.

Software sees a small register bus with single-cycle writes and a combinational read. Through it, software sets the trigger codes, a per-pin enable mask and the both-edges override. It clears recorded events by writing ones to the status register. The status bits that are both set and enabled are OR-reduced into two interrupt lines: one for the lower half of the pins and one for the upper half. This lets a system interrupt controller route the two halves separately.

Top module: `gpio_irq_top`

## Requirements
- R1: While `rst_n` is low, every register reads 0 and both `irq_lo` and `irq_hi` are low.
- R2: The trigger code of pin p (p below 16) is held in bits [2p+1:2p] of the register at offset 0x0C. The code of pin p (p 16 or above) is held in bits [2(p-16)+1:2(p-16)] of the register at offset 0x10. Both registers read back what was written.
- R3: Code 2'b00 triggers on a low pin level and code 2'b01 on a high level. The status bit is set again on every cycle the level persists, so clearing it only takes effect once the level is gone.
- R4: Code 2'b10 triggers on a rising edge and code 2'b11 on a falling edge. An edge is the pin's level differing from its level in the previous cycle. The status bit reads 1 in the cycle after the clock edge that samples the changed level.
- R5: A 1 in a pin's bit of the edge-select register (offset 0x1C) makes that pin trigger on any change of level, ignoring its trigger code.
- R6: Writing the status register (offset 0x18) clears each bit written as 1 and leaves each bit written as 0 unchanged. A write never sets a status bit.
- R7: When a trigger event and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R8: The mask register (offset 0x14) holds one enable bit per pin (1 enables). A pin's status bit is recorded even while that pin is masked.
- R9: `irq_lo` is high exactly when some pin 0 to 15 has both its status bit and its mask bit set. `irq_hi` behaves the same way for pins 16 to 31.
- R10: Offsets other than 0x0C, 0x10, 0x14, 0x18 and 0x1C read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| pad_lvl | input | NPINS | Synchronized pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr` (combinational) |
| irq_lo | output | 1 | Combined interrupt for the lower half of the pins |
| irq_hi | output | 1 | Combined interrupt for the upper half of the pins |

## Verification
The bench builds the block with its defaults: 32 pins and an 8-bit offset. This gives two 16-pin halves, with each half's codes in its own configuration register, so the bit placement of the split and both combined lines are exercised. Directed steps cover the reset-time low-level default, clearing while a level persists, the both-edges override, and an event that collides with a clear. A long random run then mixes pin toggles with writes to every register and to an unmapped offset, so that all four codes, masked and unmasked pins, and both halves are hit in many combinations.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  localparam logic [7:0] OFS_CFG_LO = 8'h0C;
  localparam logic [7:0] OFS_CFG_HI = 8'h10;
  localparam logic [7:0] OFS_MASK   = 8'h14;
  localparam logic [7:0] OFS_STATUS = 8'h18;
  localparam logic [7:0] OFS_ESEL   = 8'h1C;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] cfg_lo_q,
  output logic [NPINS-1:0] cfg_hi_q,
  output logic [NPINS-1:0] mask_q,
  output logic [NPINS-1:0] esel_q,
  output logic [NPINS-1:0] clr_vec
);
  logic we_cfg_lo, we_cfg_hi, we_mask, we_esel, we_status;
  logic [NPINS-1:0] cfg_lo_d, cfg_hi_d, mask_d, esel_d;

  always_comb begin
    we_cfg_lo = bus_wr && (bus_addr == AW'(OFS_CFG_LO));
    we_cfg_hi = bus_wr && (bus_addr == AW'(OFS_CFG_HI));
    we_mask   = bus_wr && (bus_addr == AW'(OFS_MASK));
    we_esel   = bus_wr && (bus_addr == AW'(OFS_ESEL));
    we_status = bus_wr && (bus_addr == AW'(OFS_STATUS));
    cfg_lo_d  = bus_wdata;
    cfg_hi_d  = bus_wdata;
    mask_d    = bus_wdata;
    esel_d    = bus_wdata;
    clr_vec   = we_status ? bus_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      esel_q   <= '0;
    end else begin
      if (we_cfg_lo) cfg_lo_q <= cfg_lo_d;
      if (we_cfg_hi) cfg_hi_q <= cfg_hi_d;
      if (we_mask)   mask_q   <= mask_d;
      if (we_esel)   esel_q   <= esel_d;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_lvl,
  input  logic [NPINS-1:0] cfg_lo_q,
  input  logic [NPINS-1:0] cfg_hi_q,
  input  logic [NPINS-1:0] esel_q,
  output logic [NPINS-1:0] evt
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= pad_lvl;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    trig_e code;
    logic  rise, fall;

    if (p < HALF) begin : g_lo
      assign code = trig_e'(cfg_lo_q[2*p +: 2]);
    end else begin : g_hi
      assign code = trig_e'(cfg_hi_q[2*(p-HALF) +: 2]);
    end

    always_comb begin
      rise = pad_lvl[p] && !lvl_q[p];
      fall = !pad_lvl[p] && lvl_q[p];
      if (esel_q[p]) begin
        evt[p] = rise || fall;
      end else begin
        unique case (code)
          TRIG_LOW:  evt[p] = !pad_lvl[p];
          TRIG_HIGH: evt[p] = pad_lvl[p];
          TRIG_RISE: evt[p] = rise;
          TRIG_FALL: evt[p] = fall;
          default:   evt[p] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt,
  input  logic [NPINS-1:0] clr_vec,
  input  logic [NPINS-1:0] mask_q,
  output logic [NPINS-1:0] status_q,
  output logic             irq_lo,
  output logic             irq_hi
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] status_d;
  logic [NPINS-1:0] pend;

  always_comb begin
    status_d = (status_q & ~clr_vec) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  always_comb begin
    pend   = status_q & mask_q;
    irq_lo = |pend[HALF-1:0];
    irq_hi = |pend[NPINS-1:HALF];
  end
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_lvl,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic             irq_lo,
  output logic             irq_hi
);
  logic [NPINS-1:0] cfg_lo_q, cfg_hi_q, mask_q, esel_q, clr_vec;
  logic [NPINS-1:0] evt, status_q;

  gpio_irq_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cfg_lo_q (cfg_lo_q),
    .cfg_hi_q (cfg_hi_q),
    .mask_q   (mask_q),
    .esel_q   (esel_q),
    .clr_vec  (clr_vec)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_lvl (pad_lvl),
    .cfg_lo_q(cfg_lo_q),
    .cfg_hi_q(cfg_hi_q),
    .esel_q  (esel_q),
    .evt     (evt)
  );

  gpio_irq_status #(.NPINS(NPINS)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .clr_vec (clr_vec),
    .mask_q  (mask_q),
    .status_q(status_q),
    .irq_lo  (irq_lo),
    .irq_hi  (irq_hi)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_CFG_LO))      bus_rdata = cfg_lo_q;
    else if (bus_addr == AW'(OFS_CFG_HI)) bus_rdata = cfg_hi_q;
    else if (bus_addr == AW'(OFS_MASK))   bus_rdata = mask_q;
    else if (bus_addr == AW'(OFS_STATUS)) bus_rdata = status_q;
    else if (bus_addr == AW'(OFS_ESEL))   bus_rdata = esel_q;
  end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] pad_lvl,
  input logic [NPINS-1:0] status_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] esel_q,
  input logic             irq_lo,
  input logic             irq_hi
);
  logic [NPINS-1:0] pad_d1;
  logic [NPINS-1:0] wr_ones;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pad_d1 <= '0;
    else        pad_d1 <= pad_lvl;
  end

  assign wr_ones = (bus_wr && bus_addr == AW'(OFS_STATUS)) ? bus_wdata : '0;

  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!irq_lo && !irq_hi && status_q == '0);
    end
  end

  // R6: a status bit only drops when a one was written to it
  assert_clear_only_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_q) & ~status_q & ~$past(wr_ones)) == '0));

  // R7: a bit that was set and not written with one stays set
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(status_q) & ~$past(wr_ones)) & ~status_q) == '0));

  // R5: a both-edge pin only sets when its level changed
  assert_both_edge_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((status_q & ~$past(status_q)) & $past(esel_q)
      & ~($past(pad_lvl) ^ $past(pad_d1))) == '0));

  // R8: with every pin masked neither line rises
  assert_all_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (!irq_lo && !irq_hi));
endmodule

bind gpio_irq_top gpio_irq_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .pad_lvl  (pad_lvl),
  .status_q (status_q),
  .mask_q   (mask_q),
  .esel_q   (esel_q),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi)
);

// File: tb/gpio_irq_top_tb.sv
module gpio_irq_top_tb;
  localparam int NPINS = 32;
  localparam int AW    = 8;
  localparam logic [7:0] A_CLO = 8'h0C, A_CHI = 8'h10, A_MSK = 8'h14,
                         A_ST  = 8'h18, A_ES  = 8'h1C, A_BAD = 8'h04;

  logic clk = 1'b0;
  logic rst_n;
  logic [NPINS-1:0] pad_lvl;
  logic bus_wr;
  logic [AW-1:0] bus_addr;
  logic [NPINS-1:0] bus_wdata;
  logic [NPINS-1:0] bus_rdata;
  logic irq_lo, irq_hi;

  int total = 0;
  int bad   = 0;

  logic [31:0] m_clo, m_chi, m_msk, m_st, m_es, m_lvl;

  always #5 clk = ~clk;

  gpio_irq_top #(.NPINS(NPINS), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pad_lvl(pad_lvl), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_events(input logic [31:0] pads);
    logic [31:0] ev;
    for (int p = 0; p < 32; p++) begin
      logic [1:0] code;
      logic cur, prv;
      code = (p < 16) ? m_clo[2*p +: 2] : m_chi[2*(p-16) +: 2];
      cur  = pads[p];
      prv  = m_lvl[p];
      if (m_es[p]) ev[p] = cur ^ prv;
      else case (code)
        2'b00: ev[p] = !cur;
        2'b01: ev[p] = cur;
        2'b10: ev[p] = cur & !prv;
        default: ev[p] = !cur & prv;
      endcase
    end
    return ev;
  endfunction

  // one clock with the given inputs; ends at the following falling edge
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [31:0] pads);
    logic [31:0] ev;
    bus_wr = wr; bus_addr = a; bus_wdata = d; pad_lvl = pads;
    ev = f_events(pads);
    @(posedge clk);
    m_st  = (m_st & ~((wr && a == A_ST) ? d : 32'h0)) | ev;
    m_lvl = pads;
    if (wr) begin
      case (a)
        A_CLO: m_clo = d;
        A_CHI: m_chi = d;
        A_MSK: m_msk = d;
        A_ES:  m_es  = d;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    check("R9 irq_lo", {31'b0, irq_lo}, {31'b0, |(m_st[15:0] & m_msk[15:0])});
    check("R9 irq_hi", {31'b0, irq_hi}, {31'b0, |(m_st[31:16] & m_msk[31:16])});
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_wr = 1'b0; bus_addr = a; #1;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pads;
    void'($urandom(32'hC0FFEE));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_lvl = '0;
    m_clo = 0; m_chi = 0; m_msk = 0; m_st = 0; m_es = 0; m_lvl = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    read_chk("R1 cfg_lo", A_CLO, 0);
    read_chk("R1 cfg_hi", A_CHI, 0);
    read_chk("R1 mask",   A_MSK, 0);
    read_chk("R1 status", A_ST,  0);
    read_chk("R1 esel",   A_ES,  0);
    check("R1 irqs", {30'b0, irq_hi, irq_lo}, 0);
    rst_n = 1'b1;

    // R3/R8: default low-level code with pins low sets every bit, masked
    step(0, A_CLO, 0, 0);
    read_chk("R3 low level all set", A_ST, 32'hFFFF_FFFF);
    check("R8 masked no irq", {30'b0, irq_hi, irq_lo}, 0);
    step(1, A_ST, 32'hFFFF_FFFF, 0);
    read_chk("R3 clear does not stick while level holds", A_ST, 32'hFFFF_FFFF);

    // R2 layout: lower half rising, upper half high level
    step(1, A_CLO, 32'hAAAA_AAAA, 0);
    step(1, A_CHI, 32'h5555_5555, 0);
    read_chk("R2 cfg_lo readback", A_CLO, 32'hAAAA_AAAA);
    read_chk("R2 cfg_hi readback", A_CHI, 32'h5555_5555);
    step(1, A_ST, 32'hFFFF_FFFF, 0);
    read_chk("R6 clear", A_ST, m_st);
    check("R6 clear all zero", m_st, 0);

    // R4 rising edge on pin 0
    step(0, A_CLO, 0, 32'h1);
    read_chk("R4 rising pin0", A_ST, 32'h1);
    step(0, A_CLO, 0, 32'h1);
    // R10 unmapped write ignored
    step(1, A_BAD, 32'hFFFF_FFFF, 32'h1);
    read_chk("R10 unmapped reads zero", A_BAD, 0);
    read_chk("R10 mask untouched", A_MSK, 0);
    read_chk("R10 cfg_lo untouched", A_CLO, 32'hAAAA_AAAA);
    // R6 write zeros has no effect
    step(1, A_ST, 32'h0, 32'h1);
    read_chk("R6 zero write keeps bit", A_ST, 32'h1);
    // R9 lower line
    step(1, A_MSK, 32'h1, 32'h1);
    check("R9 irq_lo on", {31'b0, irq_lo}, 1);
    check("R9 irq_hi off", {31'b0, irq_hi}, 0);

    // R5 both edges on pin 1 and R7 event beats clear
    step(1, A_ES, 32'h2, 32'h1);
    step(1, A_ST, 32'h2, 32'h3);
    read_chk("R7 event wins over clear", A_ST, 32'h3);
    step(1, A_ST, 32'h2, 32'h3);
    read_chk("R5 cleared after rise", A_ST, 32'h1);
    step(0, A_ST, 0, 32'h1);
    read_chk("R5 falling edge with esel", A_ST, 32'h3);

    // R4 falling code on pin 2: set code 11
    step(1, A_CLO, 32'hAAAA_AABA, 32'h5);
    step(1, A_ST, 32'hFFFF_FFFF, 32'h5);
    step(0, A_ST, 0, 32'h1);
    read_chk("R4 falling pin2", A_ST, 32'h4);

    // R9 upper line via pin 16 high level
    step(1, A_MSK, 32'h0001_0000, 32'h1);
    step(0, A_ST, 0, 32'h0001_0001);
    check("R9 irq_hi on", {31'b0, irq_hi}, 1);
    check("R9 irq_lo masked", {31'b0, irq_lo}, 0);
    read_chk("R8 status keeps masked bits", A_ST, m_st);

    // random phase
    pads = 32'h0001_0001;
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] sel;
      logic [7:0] a;
      logic wr;
      sel  = 3'($urandom_range(0, 5));
      case (sel)
        0: a = A_CLO; 1: a = A_CHI; 2: a = A_MSK;
        3: a = A_ST;  4: a = A_ES;  default: a = A_BAD;
      endcase
      wr   = ($urandom_range(0, 3) == 0);
      pads = pads ^ ($urandom() & $urandom() & $urandom());
      step(wr, a, $urandom(), pads);
      read_chk("R4 random status", A_ST, m_st);
    end
    read_chk("R2 random cfg_lo", A_CLO, m_clo);
    read_chk("R5 random esel", A_ES, m_es);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule